// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Reload Controller

This block decides when the staged settings of up to 64 pipeline sub-modules are copied into their working registers. Software writes a per-module enable mask, split over 32-bit words, then writes a start bit. That commit copies the mask into the soft-reset-select words and its inverse into the reload-disable words. It then sends a one-cycle reload strobe to every module whose reload-disable bit is clear.

A two-bit timing field picks when the strobe fires. In immediate mode it fires on the cycle after the start write. In frame-deferred mode the commit is held pending and fires on the next frame-end pulse. The reload-disable and soft-reset-select words can also be written directly. At a deferred fire, a module whose disable bit was set in the meantime stays on its active settings. The mask bit of each functional group is fixed: read channels from bit 0, clip units from bit 15, scalers from bit 21, colour transforms from bit 24 and overlays from bit 37.

Top module: `srr_ctrl`

## Requirements
- R1: During and after reset, every reload-disable bit is 1, every soft-reset-select bit is 0, no reload strobe is active, the timing field is 0 (immediate) and no commit is pending.
- R2: Module i is bit i mod 32 of the word numbered i div 32. Mask word k is at address 8+k, soft-reset-select word k at 16+k and reload-disable word k at 24+k. For example, overlay unit 0 (module 37) is bit 5 of word 1.
- R3: At a frame-end fire, a module whose reload-disable bit is 1 gets no strobe, even if it was enabled in the mask of the pending commit.
- R4: A start write (address 1, data bit 0 = 1) sets the soft-reset-select bits to the mask and the reload-disable bits to its inverse, visible on the cycle after the write.
- R5: A write to address 1 with data bit 0 = 0 changes no output and starts no commit.
- R6: With the timing field (address 0, bits 1:0) not equal to 1, a start write causes reload_stb to equal the mask for exactly the one cycle after the write.
- R7: With the timing field equal to 1, a start write causes no strobe. The next frame-end pulse gives reload_stb equal to the inverse of the reload-disable bits for one cycle, and the pending commit then clears.
- R8: A frame-end pulse with no pending commit gives no strobe. Two start writes before one frame end give exactly one strobe.
- R9: A direct write to a soft-reset-select or reload-disable word shows on the matching output bits on the next cycle.
- R10: Timing-field values 2 and 3 behave the same as value 0 (immediate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register word address |
| wr_data | input | 32 | Register write data |
| frame_end | input | 1 | One-cycle frame-end pulse |
| reload_stb | output | 64 | Per-module one-cycle reload strobe |
| srst_sel | output | 64 | Per-module soft-reset-select bits |
| reload_dis | output | 64 | Per-module reload-disable bits |

## Verification
A stuck or lost pending flag shows as a missing strobe at the next frame end, or as a strobe at a frame end that should have been silent, within one cycle of that pulse. A corrupted mask or disable word shows in the wrong bits of reload_stb, srst_sel or reload_dis on the cycle after the start write. A strobe that fails to clear shows one cycle later. The directed scenarios place these events in both mask words and in every timing-field value, so a mistake in word placement or mode decode reaches the ports.

// File: rtl/srr_pkg.sv
package srr_pkg;
  localparam int ADDR_W     = 5;
  localparam int A_MODE     = 0;
  localparam int A_GO       = 1;
  localparam int MASK_BASE  = 8;
  localparam int SRST_BASE  = 16;
  localparam int RDIS_BASE  = 24;
  localparam logic [1:0] MODE_AT_FRAME = 2'd1;
  // functional group base bits in the module mask
  localparam int GRP_RDMA   = 0;
  localparam int GRP_CLIP   = 15;
  localparam int GRP_SCALE  = 21;
  localparam int GRP_CTRAN  = 24;
  localparam int GRP_OVLY   = 37;
endpackage

// File: rtl/srr_word_bank.sv
module srr_word_bank
  import srr_pkg::*;
#(
  parameter int NUM_MOD = 64,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               commit,
  output logic [NUM_MOD-1:0] mask_q,
  output logic [NUM_MOD-1:0] srst_q,
  output logic [NUM_MOD-1:0] rdis_q
);
  localparam int WORDS = NUM_MOD / DW;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] AM = ADDR_W'(MASK_BASE + w);
    localparam logic [ADDR_W-1:0] AS = ADDR_W'(SRST_BASE + w);
    localparam logic [ADDR_W-1:0] AR = ADDR_W'(RDIS_BASE + w);

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[w*DW +: DW] <= '0;
      end else if (wr_en && wr_addr == AM) begin
        mask_q[w*DW +: DW] <= wr_data;
      end
    end

    // a commit takes priority over a direct write in the same cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        srst_q[w*DW +: DW] <= '0;
        rdis_q[w*DW +: DW] <= '1;
      end else if (commit) begin
        srst_q[w*DW +: DW] <= mask_q[w*DW +: DW];
        rdis_q[w*DW +: DW] <= ~mask_q[w*DW +: DW];
      end else if (wr_en) begin
        if (wr_addr == AS) srst_q[w*DW +: DW] <= wr_data;
        if (wr_addr == AR) rdis_q[w*DW +: DW] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/srr_commit_seq.sv
module srr_commit_seq
  import srr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_lsb,
  input  logic              frame_end,
  output logic              go_hit,
  output logic              fire_imm,
  output logic              fire_frame,
  output logic              pending_q,
  output logic [1:0]        mode_q
);
  logic deferred;

  assign go_hit     = wr_en && (wr_addr == ADDR_W'(A_GO)) && wr_lsb[0];
  assign deferred   = (mode_q == MODE_AT_FRAME);
  assign fire_imm   = go_hit && !deferred;
  assign fire_frame = pending_q && frame_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 2'd0;
    end else if (wr_en && wr_addr == ADDR_W'(A_MODE)) begin
      mode_q <= wr_lsb;
    end
  end

  // repeated start writes only re-arm the single pending commit
  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
    end else if (go_hit && deferred) begin
      pending_q <= 1'b1;
    end else if (fire_frame) begin
      pending_q <= 1'b0;
    end
  end
endmodule

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
#(
  parameter int NUM_MOD = 64,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [4:0]         wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               frame_end,
  output logic [NUM_MOD-1:0] reload_stb,
  output logic [NUM_MOD-1:0] srst_sel,
  output logic [NUM_MOD-1:0] reload_dis
);
  logic [NUM_MOD-1:0] mask_q;
  logic [NUM_MOD-1:0] srst_q;
  logic [NUM_MOD-1:0] rdis_q;
  logic [NUM_MOD-1:0] stb_q;
  logic               go_hit;
  logic               fire_imm;
  logic               fire_frame;
  logic               pending_q;
  logic [1:0]         mode_q;

  srr_word_bank #(.NUM_MOD(NUM_MOD), .DW(DW)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(go_hit),
    .mask_q(mask_q), .srst_q(srst_q), .rdis_q(rdis_q)
  );

  srr_commit_seq seq_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_lsb(wr_data[1:0]), .frame_end(frame_end),
    .go_hit(go_hit), .fire_imm(fire_imm), .fire_frame(fire_frame),
    .pending_q(pending_q), .mode_q(mode_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= '0;
    end else begin
      stb_q <= (fire_imm ? mask_q : '0) | (fire_frame ? ~rdis_q : '0);
    end
  end

  assign reload_stb = stb_q;
  assign srst_sel   = srst_q;
  assign reload_dis = rdis_q;
endmodule

// File: rtl/srr_ctrl_chk.sv
module srr_ctrl_chk #(
  parameter int NUM_MOD = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               frame_end,
  input logic               go_hit,
  input logic               pending_q,
  input logic [1:0]         mode_q,
  input logic [NUM_MOD-1:0] mask_q,
  input logic [NUM_MOD-1:0] reload_stb,
  input logic [NUM_MOD-1:0] srst_sel,
  input logic [NUM_MOD-1:0] reload_dis
);
  logic rst_d;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      assert_reset_vals_R1: assert (reload_dis == '1 && srst_sel == '0
                                    && reload_stb == '0 && !pending_q);
    end
  end

  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (rst)
    go_hit |=> (srst_sel == $past(mask_q) && reload_dis == ~$past(mask_q)));

  assert_imm_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (go_hit && mode_q != 2'd1 && !(pending_q && frame_end))
      |=> reload_stb == $past(mask_q));

  assert_pending_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (pending_q && frame_end && !go_hit) |=> !pending_q);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!go_hit && !(pending_q && frame_end)) |=> reload_stb == '0);
endmodule

bind srr_ctrl srr_ctrl_chk #(.NUM_MOD(NUM_MOD)) chk_i (
  .clk(clk), .rst(rst), .frame_end(frame_end), .go_hit(go_hit),
  .pending_q(pending_q), .mode_q(mode_q), .mask_q(mask_q),
  .reload_stb(reload_stb), .srst_sel(srst_sel), .reload_dis(reload_dis)
);

// File: tb/srr_ctrl_tb.sv
module srr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        frame_end;
  logic [63:0] reload_stb, srst_sel, reload_dis;
  int n_chk = 0;
  int n_bad = 0;
  bit timed_out = 0;

  always #5 clk = ~clk;

  srr_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_end(frame_end),
    .reload_stb(reload_stb), .srst_sel(srst_sel), .reload_dis(reload_dis)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge; outputs of the capturing edge are sampled at the next negedge
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fe();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic set_mask(input logic [63:0] m);
    wr(8, m[31:0]);
    wr(9, m[63:32]);
  endtask

  task automatic t_reset();
    chk("R1 rdis", reload_dis, '1);
    chk("R1 srst", srst_sel, '0);
    chk("R1 stb", reload_stb, '0);
    fe();
    chk("R1 no pending at frame end", reload_stb, '0);
  endtask

  task automatic t_immediate();
    logic [63:0] m = 64'h0000_0020_0000_8001; // module 37 = overlay 0, word 1 bit 5
    set_mask(m);
    wr(1, 32'h1);
    chk("R6 R2 strobe", reload_stb, m);
    chk("R4 srst", srst_sel, m);
    chk("R4 rdis", reload_dis, ~m);
    @(negedge clk);
    chk("R6 one cycle", reload_stb, '0);
  endtask

  task automatic t_go_zero();
    set_mask(64'hFFFF_0000_0000_FFFF);
    wr(1, 32'h0);
    chk("R5 stb", reload_stb, '0);
    chk("R5 srst", srst_sel, 64'h0000_0020_0000_8001);
    chk("R5 rdis", reload_dis, ~64'h0000_0020_0000_8001);
  endtask

  task automatic t_deferred();
    logic [63:0] m = 64'h1234_0000_0ABC_0000;
    wr(0, 32'h1);
    set_mask(m);
    wr(1, 32'h1);
    chk("R7 no strobe at go", reload_stb, '0);
    chk("R4 deferred srst", srst_sel, m);
    repeat (3) @(negedge clk);
    chk("R7 idle", reload_stb, '0);
    fe();
    chk("R7 frame fire", reload_stb, m);
    @(negedge clk);
    chk("R7 one cycle", reload_stb, '0);
    fe();
    chk("R7 pending cleared", reload_stb, '0);
  endtask

  task automatic t_double_go();
    logic [63:0] m = 64'h8000_0001_4000_0002;
    set_mask(m);
    wr(1, 32'h1);
    wr(1, 32'h1);
    fe();
    chk("R8 single strobe", reload_stb, m);
    fe();
    chk("R8 no second strobe", reload_stb, '0);
  endtask

  task automatic t_override();
    set_mask('1);
    wr(1, 32'h1);
    wr(24, 32'hFFFF_FFFF);
    chk("R9 rdis direct", reload_dis, 64'hFFFF_FFFF);
    wr(17, 32'h0000_00A5);
    chk("R9 srst direct", srst_sel, 64'h0000_00A5_FFFF_FFFF);
    fe();
    chk("R3 disabled ignored", reload_stb, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_other_modes();
    logic [63:0] m = 64'h0000_0001_0020_0000; // scaler 0 and bit 32
    set_mask(m);
    wr(0, 32'h2);
    wr(1, 32'h1);
    chk("R10 mode 2 immediate", reload_stb, m);
    wr(0, 32'h3);
    wr(1, 32'h1);
    chk("R10 mode 3 immediate", reload_stb, m);
    wr(0, 32'h0);
    wr(1, 32'h1);
    chk("R6 mode 0 immediate", reload_stb, m);
  endtask

  task automatic run_all();
    t_reset();
    t_immediate();
    t_go_zero();
    t_deferred();
    t_double_go();
    t_override();
    t_other_modes();
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; frame_end = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule